// File: doc/BRIEF.md
# Serial Frame Aligner with Programmable Start Offset

This block is the receive front end for a group of serial input streams that share one bit clock and one frame pulse. It turns the frame pulse into an internal frame-start strobe, keeps a bit-in-channel counter and a channel counter, and turns each serial line into bytes, with a byte-valid strobe for each stream.

A small register port sets how many bit-clock periods pass after the frame pulse before the first bit of the frame is captured. This lets the receiver follow streams whose first bit arrives late compared with the frame pulse. The delay can be 0 to 4 periods. Codes outside that range are treated as no delay and set a sticky error bit, which software reads and clears through the same port.

Top module: `sfa_frame_align`

## Requirements
- R1: After synchronous reset, frame_start, byte_valid, bit_idx and chan_idx are all zero. Register 0 and register 1 both read 8'h00.
- R2: Register 0 (reg_addr=0) holds the 3-bit offset code in bits 7:5. Bits 4:0 are ignored on write and read back as zero. The stored code reads back as written, reserved values included.
- R3: With code 0, frame_start is high in the cycle that follows the clock edge that samples fp_in high. That same edge captures the first (most significant) bit of channel 0.
- R4: With code d in 1..4, frame_start and capture of the first bit occur d clock edges after the edge that samples fp_in. frame_start stays low in the cycles before that.
- R5: Codes 5, 6 and 7 give the same timing as code 0. Writing one of them sets bit 0 of register 1 (reg_addr=1). That bit stays set until a write to register 1 with bit 0 high clears it. A write to register 1 with bit 0 low leaves it set.
- R6: bit_idx reads 0 after the frame-start edge and increments by one on each later edge, wrapping after 7. chan_idx reads 0 after the frame-start edge, increments when bit_idx wraps from 7 to 0, and wraps from NUM_CHANS-1 to 0.
- R7: Bits are assembled MSB first. byte_valid is high for exactly one cycle, after the edge that captures bit index 7. During that cycle, byte_data[8s+7:8s] holds the completed byte of stream s.
- R8: A write to register 0 during a frame does not change the timing of that frame. The new code applies from the next frame pulse.
- R9: A frame pulse that arrives while an offset delay is still counting restarts the delay from that pulse. The earlier pulse produces no frame_start.
- R10: No byte_valid is produced between reset and the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| fp_in | input | 1 | External frame pulse, sampled on the rising edge |
| sdin | input | NUM_STREAMS | Serial input lines, one per stream |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 offset, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| frame_start | output | 1 | One-cycle strobe after the first-bit capture edge |
| bit_idx | output | 3 | Index of the bit captured at the last edge |
| chan_idx | output | CHAN_W | Channel counter within the frame |
| byte_data | output | 8*NUM_STREAMS | Assembled bytes, stream s in bits 8s+7:8s |
| byte_valid | output | NUM_STREAMS | Byte-ready strobe per stream |

## Verification
The embedded properties check several behaviours on every cycle. They check that a pulse with zero delay is always followed by a frame start, and that a pulse with a non-zero delay never is. They check that a reserved write always raises the error bit and that only an explicit clear drops it. They check that byte strobes only appear when the bit index is 7 and never before the first frame start, and that the channel counter moves when the bit counter wraps. The directed scenarios cover what the properties cannot: the exact cycle of the frame start for each offset, the byte values in MSB-first order, channel wrap, a mid-frame offset change applying only from the next pulse, and a second pulse restarting a pending delay.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int CODE_W    = 3;
    localparam int MAX_DELAY = 4;
    localparam int BYTE_W    = 8;

    localparam logic ADDR_OFFSET = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    typedef logic [CODE_W-1:0] ofs_code_t;

    typedef struct packed {
        logic      armed;
        ofs_code_t left;
    } dly_state_t;

    function automatic logic code_reserved(input ofs_code_t c);
        return c > ofs_code_t'(MAX_DELAY);
    endfunction

    function automatic ofs_code_t code_to_delay(input ofs_code_t c);
        return code_reserved(c) ? '0 : c;
    endfunction

endpackage

// File: rtl/sfa_cfg_regs.sv
module sfa_cfg_regs
    import sfa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output ofs_code_t   delay
);

    ofs_code_t code_q;
    logic      err_q;
    logic      wr_code;
    logic      wr_clear;

    assign wr_code  = reg_wr && (reg_addr == ADDR_OFFSET);
    assign wr_clear = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_code) begin
                code_q <= reg_wdata[7:5];
                if (code_reserved(reg_wdata[7:5]))
                    err_q <= 1'b1;
            end else if (wr_clear) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (reg_addr == ADDR_OFFSET)
            reg_rdata = {code_q, 5'b0};
        else
            reg_rdata = {7'b0, err_q};
    end

    assign delay = code_to_delay(code_q);

    assert_reserved_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_code && code_reserved(reg_wdata[7:5])) |=> err_q);

    assert_sticky_error_R5: assert property (@(posedge clk) disable iff (rst)
        (err_q && !wr_clear) |=> err_q);

    assert_delay_range_R2: assert property (@(posedge clk) disable iff (rst)
        delay <= ofs_code_t'(MAX_DELAY));

endmodule

// File: rtl/sfa_frame_timer.sv
module sfa_frame_timer
    import sfa_pkg::*;
#(
    parameter int NUM_CHANS = 32,
    localparam int CHAN_W   = $clog2(NUM_CHANS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fp_in,
    input  ofs_code_t         delay,
    output logic              frame_start,
    output logic [2:0]        bit_idx,
    output logic [CHAN_W-1:0] chan_idx,
    output logic              locked,
    output logic              last_bit
);

    dly_state_t st_q;
    logic       go;

    assign go = (fp_in && delay == '0) ||
                (!fp_in && st_q.armed && st_q.left == ofs_code_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (fp_in) begin
            st_q.armed <= (delay != '0);
            st_q.left  <= delay;
        end else if (st_q.armed) begin
            st_q.left <= st_q.left - ofs_code_t'(1);
            if (st_q.left == ofs_code_t'(1))
                st_q.armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
            bit_idx     <= '0;
            chan_idx    <= '0;
            locked      <= 1'b0;
        end else begin
            frame_start <= go;
            if (go) begin
                bit_idx  <= '0;
                chan_idx <= '0;
                locked   <= 1'b1;
            end else begin
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) begin
                    if (chan_idx == CHAN_W'(NUM_CHANS - 1))
                        chan_idx <= '0;
                    else
                        chan_idx <= chan_idx + CHAN_W'(1);
                end
            end
        end
    end

    assign last_bit = locked && !go && (bit_idx == 3'd6);

    assert_zero_delay_start_R3: assert property (@(posedge clk) disable iff (rst)
        (fp_in && delay == '0) |=> frame_start);

    assert_delayed_no_early_start_R4: assert property (@(posedge clk) disable iff (rst)
        (fp_in && delay != '0) |=> !frame_start);

    assert_pulse_restarts_count_R9: assert property (@(posedge clk) disable iff (rst)
        fp_in |=> (st_q.armed == ($past(delay) != '0)));

    assert_channel_advances_R6: assert property (@(posedge clk) disable iff (rst)
        (locked && !go && bit_idx == 3'd7) |=> (chan_idx != $past(chan_idx) || NUM_CHANS == 1));

endmodule

// File: rtl/sfa_deser.sv
module sfa_deser
    import sfa_pkg::*;
#(
    parameter int NUM_STREAMS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_STREAMS-1:0]        sdin,
    input  logic                          last_bit,
    output logic [NUM_STREAMS*BYTE_W-1:0] byte_data,
    output logic [NUM_STREAMS-1:0]        byte_valid
);

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
        logic [BYTE_W-2:0] shift_q;
        logic [BYTE_W-1:0] data_q;
        logic              valid_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shift_q <= '0;
                data_q  <= '0;
                valid_q <= 1'b0;
            end else begin
                shift_q <= {shift_q[BYTE_W-3:0], sdin[s]};
                valid_q <= last_bit;
                if (last_bit)
                    data_q <= {shift_q, sdin[s]};
            end
        end

        assign byte_data[s*BYTE_W +: BYTE_W] = data_q;
        assign byte_valid[s]                 = valid_q;

        assert_single_cycle_valid_R7: assert property (@(posedge clk) disable iff (rst)
            valid_q |=> !valid_q);
    end

endmodule

// File: rtl/sfa_frame_align.sv
module sfa_frame_align
    import sfa_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int NUM_CHANS   = 32,
    localparam int CHAN_W     = $clog2(NUM_CHANS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fp_in,
    input  logic [NUM_STREAMS-1:0]        sdin,
    input  logic                          reg_wr,
    input  logic                          reg_addr,
    input  logic [7:0]                    reg_wdata,
    output logic [7:0]                    reg_rdata,
    output logic                          frame_start,
    output logic [2:0]                    bit_idx,
    output logic [CHAN_W-1:0]             chan_idx,
    output logic [NUM_STREAMS*BYTE_W-1:0] byte_data,
    output logic [NUM_STREAMS-1:0]        byte_valid
);

    ofs_code_t delay;
    logic      locked;
    logic      last_bit;

    sfa_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .delay     (delay)
    );

    sfa_frame_timer #(.NUM_CHANS(NUM_CHANS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .fp_in       (fp_in),
        .delay       (delay),
        .frame_start (frame_start),
        .bit_idx     (bit_idx),
        .chan_idx    (chan_idx),
        .locked      (locked),
        .last_bit    (last_bit)
    );

    sfa_deser #(.NUM_STREAMS(NUM_STREAMS)) u_deser (
        .clk        (clk),
        .rst        (rst),
        .sdin       (sdin),
        .last_bit   (last_bit),
        .byte_data  (byte_data),
        .byte_valid (byte_valid)
    );

    assert_byte_on_last_bit_R7: assert property (@(posedge clk) disable iff (rst)
        byte_valid[0] |-> (bit_idx == 3'd7));

    assert_no_bytes_unlocked_R10: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (byte_valid == '0));

endmodule

// File: tb/sfa_frame_align_test.sv
module sfa_frame_align_test;

    localparam int NS = 4;
    localparam int NC = 32;
    localparam int CW = $clog2(NC);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fp_in = 1'b0;
    logic [NS-1:0]     sdin = '0;
    logic              reg_wr = 1'b0;
    logic              reg_addr = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              frame_start;
    logic [2:0]        bit_idx;
    logic [CW-1:0]     chan_idx;
    logic [NS*8-1:0]   byte_data;
    logic [NS-1:0]     byte_valid;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sfa_frame_align #(.NUM_STREAMS(NS), .NUM_CHANS(NC)) uut (
        .clk(clk), .rst(rst), .fp_in(fp_in), .sdin(sdin),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .frame_start(frame_start), .bit_idx(bit_idx),
        .chan_idx(chan_idx), .byte_data(byte_data), .byte_valid(byte_valid)
    );

    function automatic logic [7:0] exp_byte(input int s, input int n);
        return 8'((s * 37 + n * 11 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_chk(input logic a, input logic [7:0] expv, input string req);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        chk(reg_rdata === expv, req, int'(reg_rdata), int'(expv));
    endtask

    // d: effective delay; fp2: cycle of a second pulse (-1 none); wr_at: cycle of a mid-frame write
    task automatic run_frame(input int d, input int nbytes, input int fp2,
                             input int wr_at, input logic [7:0] wr_val, input string req);
        int start = ((fp2 >= 0) ? fp2 : 0) + d;
        for (int c = 0; c < start + 8 * nbytes; c++) begin
            @(negedge clk);
            fp_in  = (c == 0) || (c == fp2);
            reg_wr = (c == wr_at);
            reg_addr = 1'b0;
            reg_wdata = wr_val;
            for (int s = 0; s < NS; s++) begin
                if (c >= start) begin
                    logic [7:0] b;
                    b = exp_byte(s, (c - start) / 8);
                    sdin[s] = b[7 - ((c - start) % 8)];
                end else begin
                    sdin[s] = ~c[0];
                end
            end
            @(posedge clk);
            #1;
            chk(frame_start === (c == start), {req, " frame_start"}, int'(frame_start), int'(c == start));
            if (c >= start) begin
                int i = c - start;
                chk(bit_idx == 3'(i % 8), "R6 bit_idx", int'(bit_idx), i % 8);
                chk(chan_idx == CW'((i / 8) % NC), "R6 chan_idx", int'(chan_idx), (i / 8) % NC);
                chk(byte_valid === ((i % 8 == 7) ? {NS{1'b1}} : {NS{1'b0}}), "R7 byte_valid",
                    int'(byte_valid), (i % 8 == 7) ? (1 << NS) - 1 : 0);
                if (i % 8 == 7)
                    for (int s = 0; s < NS; s++)
                        chk(byte_data[s*8 +: 8] === exp_byte(s, i / 8), "R7 byte_data",
                            int'(byte_data[s*8 +: 8]), int'(exp_byte(s, i / 8)));
            end
        end
        @(negedge clk);
        fp_in = 1'b0;
        reg_wr = 1'b0;
    endtask

    task automatic test_reset();
        #0.5;
        chk(frame_start === 1'b0, "R1 frame_start", int'(frame_start), 0);
        chk(byte_valid === '0, "R1 byte_valid", int'(byte_valid), 0);
        chk(bit_idx === '0, "R1 bit_idx", int'(bit_idx), 0);
        chk(chan_idx === '0, "R1 chan_idx", int'(chan_idx), 0);
        read_chk(1'b0, 8'h00, "R1 offset reg");
        read_chk(1'b1, 8'h00, "R1 status reg");
    endtask

    task automatic test_no_bytes_before_lock();
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            sdin = NS'(c * 5);
            @(posedge clk);
            #1;
            chk(byte_valid === '0, "R10 byte_valid before first frame", int'(byte_valid), 0);
            chk(frame_start === 1'b0, "R10 frame_start before pulse", int'(frame_start), 0);
        end
    endtask

    task automatic test_offsets();
        run_frame(0, 3, -1, -1, 8'h00, "R3");
        for (int d = 1; d <= 4; d++) begin
            write_reg(1'b0, {3'(d), 5'h1F});
            read_chk(1'b0, {3'(d), 5'h00}, "R2 readback");
            run_frame(d, 2, -1, -1, 8'h00, "R4");
        end
    endtask

    task automatic test_reserved();
        write_reg(1'b0, 8'hA0);
        read_chk(1'b1, 8'h01, "R5 error set");
        read_chk(1'b0, 8'hA0, "R2 reserved readback");
        run_frame(0, 2, -1, -1, 8'h00, "R5");
        write_reg(1'b1, 8'h00);
        read_chk(1'b1, 8'h01, "R5 error held");
        write_reg(1'b0, 8'h20);
        read_chk(1'b1, 8'h01, "R5 error held on valid code");
        write_reg(1'b1, 8'h01);
        read_chk(1'b1, 8'h00, "R5 error cleared");
        write_reg(1'b0, 8'hE0);
        read_chk(1'b1, 8'h01, "R5 error set by 111");
        run_frame(0, 1, -1, -1, 8'h00, "R5");
        write_reg(1'b1, 8'h01);
    endtask

    task automatic test_chan_wrap();
        write_reg(1'b0, 8'h00);
        run_frame(0, NC + 2, -1, -1, 8'h00, "R6");
    endtask

    task automatic test_mid_frame_write();
        write_reg(1'b0, 8'h40);
        run_frame(2, 3, -1, 6, 8'h80, "R8");
        read_chk(1'b0, 8'h80, "R8 new code stored");
        run_frame(4, 1, -1, -1, 8'h80, "R8");
    endtask

    task automatic test_restart();
        write_reg(1'b0, 8'h60);
        run_frame(3, 2, 1, -1, 8'h60, "R9");
        run_frame(3, 1, 2, -1, 8'h60, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_no_bytes_before_lock();
        test_offsets();
        test_reserved();
        test_chan_wrap();
        test_mid_frame_write();
        test_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule